// File: doc/BRIEF.md
# ADC Scan Sequencer Controller

This block drives an external analog-to-digital converter through a programmed list of channel numbers. Software loads up to sixteen 5-bit channel numbers and a scan length into three list registers. A scan then starts either from a software start bit or from an edge on one of sixteen external trigger lines. For each list entry in turn, the controller presents the channel number, pulses a start strobe and waits for the converter's done strobe with its 12-bit result.

Every result lands in a data register and sets an end-of-conversion flag. Reading the data register clears the flag. A result that replaces unread data sets a sticky overrun flag. An interrupt output follows the end-of-conversion flag when the interrupt enable is set. The trigger lines are asynchronous: they pass through a synchronizer before edge detection. While a scan is running, trigger edges are ignored.

Register word offsets on `reg_addr`: 0 control, 1 upper list (slots 13 to 16 and length), 2 middle list (slots 7 to 12), 3 lower list (slots 1 to 6), 4 status, 5 data. Unused bits read as zero.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `conv_start` is low.
- R2: Slot n is stored as a 5-bit field: slots 1 to 6 in the lower list at bit 5*(n-1), slots 7 to 12 in the middle list at bit 5*(n-7), slots 13 to 16 in the upper list at bit 5*(n-13). Each conversion presents its slot's channel on `conv_chan` while `conv_start` is high.
- R3: The scan length field is bits 23:20 of the upper list and holds the conversion count minus one. A scan performs exactly length+1 conversions from slot 1 upward. Each conversion is one single-cycle `conv_start`, and the next conversion issues only after `conv_done`.
- R4: Each accepted `conv_done` stores `conv_result` in data bits 11:0 and sets status bit 0. A data-register read clears status bit 0, unless a new result arrives in the same cycle.
- R5: A result that arrives while status bit 0 is set and no data read occurs in that cycle sets status bit 1. Status bit 1 stays set until a status write with bit 1 set.
- R6: `irq` is high exactly when status bit 0 is set and control bit 1 (interrupt enable) is set.
- R7: Control bit 30 requests a software start. It is stored only when control bit 0 (enable) is written as 1 in the same write, reads back 1 while pending, and clears when the scan begins. A request written with enable 0 causes no conversion.
- R8: Control bits 29:28 select the trigger edge: 00 none, 01 rising, 10 falling, 11 both. Control bits 27:24 pick which `trig_in` line is watched. Edges on other lines start nothing.
- R9: A trigger edge that occurs while a scan is in progress (status bit 2 high) does not start another scan.
- R10: Clearing control bit 0 during a scan ends it: no further `conv_start` is issued, and status bit 2 goes low on the next cycle.
- R11: A software start written while a scan is running stays pending and starts a new full scan once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data register) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| trig_in | input | 16 | Asynchronous external trigger lines |
| conv_chan | output | 5 | Channel number for the current conversion |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The bench runs every scan length from one to sixteen against a distinct channel pattern. A design that misplaces a slot field or miscounts the minus-one length presents a wrong channel or stops one conversion early or late. All four edge modes are run on several source lines, together with edges on a neighbouring unselected line. A design with a swapped edge encoding or a bad source mux starts the wrong number of scans. The bench also re-fires the trigger mid-scan, issues a software start with the block disabled, queues a software start during a scan and disables the block mid-scan. These cases catch a restartable scan, a sticky start bit that ignores enable, a lost pending start, and an abort that keeps issuing conversions. The overrun flag, the interrupt and the read-to-clear behaviour are checked after every scan.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int CHAN_W        = 5;
    localparam int RES_W         = 12;
    localparam int SLOTS         = 16;
    localparam int LEN_W         = $clog2(SLOTS);
    localparam int TRIG_N        = 16;
    localparam int TSEL_W        = $clog2(TRIG_N);
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int SLOTS_PER_REG = 6;
    localparam int TOP_SLOTS     = SLOTS - 2 * SLOTS_PER_REG;
    localparam int LEN_LSB       = 20;
    localparam int SYNC_STAGES   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEQ_TOP = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEQ_MID = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEQ_LOW = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd4;
    localparam logic [ADDR_W-1:0] A_DATA    = 3'd5;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic              sw_start;
        edge_mode_e        edge_mode;
        logic [TSEL_W-1:0] tsel;
        logic              irq_en;
        logic              enable;
    } ctrl_t;

    typedef struct packed {
        logic [SLOTS-1:0][CHAN_W-1:0] slots;
        logic [LEN_W-1:0]             len;
        ctrl_t                        ctrl;
        logic [RES_W-1:0]             data;
        logic                         eoc;
        logic                         ovr;
    } regs_t;

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect
    import scan_seq_pkg::*;
#(
    parameter int N      = TRIG_N,
    parameter int SEL_W  = TSEL_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     trig_in,
    input  logic [SEL_W-1:0] sel,
    input  edge_mode_e       mode,
    output logic             edge_hit
);

    logic [STAGES-1:0][N-1:0] sync_d, sync_q;
    logic                     prev_d, prev_q;
    logic                     level;
    logic                     rise, fall;

    always_comb begin
        sync_d[0] = trig_in;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
        level  = sync_q[STAGES-1][sel];
        prev_d = level;
        rise   = level & ~prev_q;
        fall   = ~level & prev_q;
        case (mode)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/seq_slot_mux.sv
module seq_slot_mux
    import scan_seq_pkg::*;
#(
    parameter int N  = SLOTS,
    parameter int W  = CHAN_W,
    parameter int IW = LEN_W
) (
    input  logic [N-1:0][W-1:0] slots,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        chan
);

    always_comb begin
        chan = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IW'(k)) begin
                chan = slots[k];
            end
        end
    end

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_seq_pkg::*;
#(
    parameter int IW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start_req,
    input  logic          conv_done,
    input  logic [IW-1:0] len,
    output logic          conv_start,
    output logic          busy,
    output logic          take,
    output logic          scan_begin,
    output logic [IW-1:0] idx
);

    typedef struct packed {
        scan_state_e   state;
        logic [IW-1:0] idx;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        scan_begin = 1'b0;
        take       = 1'b0;
        case (fsm_q.state)
            ST_IDLE: begin
                if (enable && start_req) begin
                    fsm_d.state = ST_ISSUE;
                    fsm_d.idx   = '0;
                    scan_begin  = 1'b1;
                end
            end
            ST_ISSUE: begin
                fsm_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done && enable) begin
                    take = 1'b1;
                    if (fsm_q.idx == len) begin
                        fsm_d.state = ST_IDLE;
                    end else begin
                        fsm_d.idx   = fsm_q.idx + 1'b1;
                        fsm_d.state = ST_ISSUE;
                    end
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
        if (!enable) begin
            fsm_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, idx: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign conv_start = (fsm_q.state == ST_ISSUE);
    assign busy       = (fsm_q.state != ST_IDLE);
    assign idx        = fsm_q.idx;

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [TRIG_N-1:0] trig_in,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);

    regs_t      regs_d, regs_q;
    logic       trig_hit;
    logic       start_req;
    logic       busy;
    logic       take;
    logic       scan_begin;
    logic       data_read;
    logic       en_w, eoc_w, ovr_w;
    logic [LEN_W-1:0] idx;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata;

    trig_edge_detect #(
        .N      (TRIG_N),
        .SEL_W  (TSEL_W),
        .STAGES (SYNC_STAGES)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .sel      (regs_q.ctrl.tsel),
        .mode     (regs_q.ctrl.edge_mode),
        .edge_hit (trig_hit)
    );

    assign start_req = regs_q.ctrl.sw_start | trig_hit;

    scan_fsm #(
        .IW (LEN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (regs_q.ctrl.enable),
        .start_req  (start_req),
        .conv_done  (conv_done),
        .len        (regs_q.len),
        .conv_start (conv_start),
        .busy       (busy),
        .take       (take),
        .scan_begin (scan_begin),
        .idx        (idx)
    );

    seq_slot_mux #(
        .N  (SLOTS),
        .W  (CHAN_W),
        .IW (LEN_W)
    ) u_mux (
        .slots (regs_q.slots),
        .idx   (idx),
        .chan  (conv_chan)
    );

    assign data_read = reg_rd && (reg_addr == A_DATA);

    // next-state of the register file
    always_comb begin
        regs_d = regs_q;

        if (scan_begin) begin
            regs_d.ctrl.sw_start = 1'b0;
        end

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    regs_d.ctrl.enable    = reg_wdata[0];
                    regs_d.ctrl.irq_en    = reg_wdata[1];
                    regs_d.ctrl.tsel      = reg_wdata[24 +: TSEL_W];
                    regs_d.ctrl.edge_mode = edge_mode_e'(reg_wdata[29:28]);
                    regs_d.ctrl.sw_start  = reg_wdata[0] &
                                            (reg_wdata[30] | regs_d.ctrl.sw_start);
                end
                A_SEQ_LOW: begin
                    for (int k = 0; k < SLOTS_PER_REG; k++) begin
                        regs_d.slots[k] = reg_wdata[k*CHAN_W +: CHAN_W];
                    end
                end
                A_SEQ_MID: begin
                    for (int k = 0; k < SLOTS_PER_REG; k++) begin
                        regs_d.slots[SLOTS_PER_REG + k] = reg_wdata[k*CHAN_W +: CHAN_W];
                    end
                end
                A_SEQ_TOP: begin
                    for (int k = 0; k < TOP_SLOTS; k++) begin
                        regs_d.slots[2*SLOTS_PER_REG + k] = reg_wdata[k*CHAN_W +: CHAN_W];
                    end
                    regs_d.len = reg_wdata[LEN_LSB +: LEN_W];
                end
                A_STAT: begin
                    if (reg_wdata[1]) begin
                        regs_d.ovr = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (data_read) begin
            regs_d.eoc = 1'b0;
        end

        if (take) begin
            regs_d.data = conv_result;
            regs_d.eoc  = 1'b1;
            if (regs_q.eoc && !data_read) begin
                regs_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]               = regs_q.ctrl.enable;
                reg_rdata[1]               = regs_q.ctrl.irq_en;
                reg_rdata[24 +: TSEL_W]    = regs_q.ctrl.tsel;
                reg_rdata[29:28]           = regs_q.ctrl.edge_mode;
                reg_rdata[30]              = regs_q.ctrl.sw_start;
            end
            A_SEQ_LOW: begin
                for (int k = 0; k < SLOTS_PER_REG; k++) begin
                    reg_rdata[k*CHAN_W +: CHAN_W] = regs_q.slots[k];
                end
            end
            A_SEQ_MID: begin
                for (int k = 0; k < SLOTS_PER_REG; k++) begin
                    reg_rdata[k*CHAN_W +: CHAN_W] = regs_q.slots[SLOTS_PER_REG + k];
                end
            end
            A_SEQ_TOP: begin
                for (int k = 0; k < TOP_SLOTS; k++) begin
                    reg_rdata[k*CHAN_W +: CHAN_W] = regs_q.slots[2*SLOTS_PER_REG + k];
                end
                reg_rdata[LEN_LSB +: LEN_W] = regs_q.len;
            end
            A_STAT: begin
                reg_rdata[0] = regs_q.eoc;
                reg_rdata[1] = regs_q.ovr;
                reg_rdata[2] = busy;
            end
            A_DATA: begin
                reg_rdata[RES_W-1:0] = regs_q.data;
            end
            default: ;
        endcase
    end

    assign irq   = regs_q.eoc & regs_q.ctrl.irq_en;
    assign en_w  = regs_q.ctrl.enable;
    assign eoc_w = regs_q.eoc;
    assign ovr_w = regs_q.ovr;

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
    import scan_seq_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic conv_done,
    input logic busy,
    input logic enable,
    input logic eoc,
    input logic ovr,
    input logic data_read,
    input logic take
);

    localparam int CNT_W = $clog2(SLOTS + 1) + 1;

    logic [CNT_W-1:0] starts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            starts_q <= '0;
        end else if (!busy) begin
            starts_q <= '0;
        end else if (conv_start) begin
            starts_q <= starts_q + 1'b1;
        end
    end

    // R3: start strobe lasts one cycle
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R3: no scan issues more starts than there are slots
    assert_scan_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        starts_q <= CNT_W'(SLOTS));

    // R4: accepted result raises the flag
    assert_eoc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> eoc);

    // R4: data read without new result clears the flag
    assert_eoc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && !take) |=> !eoc);

    // R5: unread data overwritten sets overrun
    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && eoc && !data_read) |=> ovr);

    // R10: disable ends a scan on the next cycle
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !enable) |=> !busy);

    // R10: no start strobe while disabled
    assert_no_start_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !conv_start);

    // R4: results are taken only as the converter reports done
    assert_take_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> conv_done);

endmodule

bind scan_seq_ctrl scan_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .busy       (busy),
    .enable     (en_w),
    .eoc        (eoc_w),
    .ovr        (ovr_w),
    .data_read  (data_read),
    .take       (take)
);

// File: tb/sim_scan_seq_ctrl.sv
`timescale 1ns/1ps
module sim_scan_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] trig_in = '0;
    logic [4:0]  conv_chan;
    logic        conv_start;
    logic        conv_done;
    logic [11:0] conv_result;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    scan_seq_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .trig_in     (trig_in),
        .conv_chan   (conv_chan),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .irq         (irq)
    );

    function automatic logic [11:0] res_of(input logic [4:0] ch);
        return 12'((32'(ch) * 131 + 17) & 32'hFFF);
    endfunction

    // converter stub: fixed latency, result derived from the channel
    bit [2:0]   lat_q;
    int         conv_cnt = 0;
    logic [4:0] chan_log [0:255];

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (lat_q != 0) begin
            lat_q <= lat_q - 1'b1;
            if (lat_q == 3'd1) conv_done <= 1'b1;
        end
        if (conv_start) begin
            lat_q <= 3'd3;
            conv_result <= res_of(conv_chan);
            chan_log[8'(conv_cnt)] <= conv_chan;
            conv_cnt <= conv_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        cycles(3);
        for (int i = 0; i < 2000; i++) begin
            rd(3'd4, s);
            if (s[2] == 1'b0) break;
        end
    endtask

    logic [4:0] pat [0:15];

    task automatic load_list(input int len);
        logic [31:0] lo, mi, hi;
        lo = '0; mi = '0; hi = '0;
        for (int k = 0; k < 6; k++) lo[k*5 +: 5] = pat[k];
        for (int k = 0; k < 6; k++) mi[k*5 +: 5] = pat[6 + k];
        for (int k = 0; k < 4; k++) hi[k*5 +: 5] = pat[12 + k];
        hi[23:20] = 4'(len);
        wr(3'd3, lo);
        wr(3'd2, mi);
        wr(3'd1, hi);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        int expn;

        cycles(5);
        rst_n = 1'b1;
        cycles(2);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg reset", v, 32'h0);
        end
        #1;
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 start reset", {31'b0, conv_start}, 32'h0);

        // R2 R3 R4 R5 R7: every scan length with its own channel pattern
        for (int len = 0; len < 16; len++) begin
            for (int i = 0; i < 16; i++) pat[i] = 5'((i * 7 + len * 3 + 1) % 32);
            load_list(len);
            rd(3'd3, v);
            chk("R2 low list readback", v, {2'b0, pat[5], pat[4], pat[3], pat[2], pat[1], pat[0]});
            base = conv_cnt;
            wr(3'd0, 32'h4000_0001);
            wait_idle();
            chk("R3 conversion count", 32'(conv_cnt - base), 32'(len + 1));
            for (int i = 0; i <= len; i++) begin
                chk("R2 slot channel", {27'b0, chan_log[8'(base + i)]}, {27'b0, pat[i]});
            end
            rd(3'd0, v);
            chk("R7 start bit self-clear", v, 32'h0000_0001);
            #1 chk("R6 irq off when disabled", {31'b0, irq}, 32'h0);
            rd(3'd4, v);
            chk("R4 R5 status after scan", v, {30'b0, (len > 0), 1'b1});
            rd(3'd5, v);
            chk("R4 data value", v, {20'b0, res_of(pat[len])});
            rd(3'd4, v);
            chk("R4 eoc cleared by read", v, {30'b0, (len > 0), 1'b0});
            wr(3'd4, 32'h2);
            rd(3'd4, v);
            chk("R5 overrun cleared", v, 32'h0);
        end

        // R6 interrupt follows flag when enabled
        for (int i = 0; i < 16; i++) pat[i] = 5'(31 - i);
        load_list(0);
        wr(3'd0, 32'h4000_0003);
        wait_idle();
        #1 chk("R6 irq raised", {31'b0, irq}, 32'h1);
        rd(3'd5, v);
        chk("R6 data", v, {20'b0, res_of(5'd31)});
        #1 chk("R6 irq dropped after read", {31'b0, irq}, 32'h0);

        // R7 software start with enable low does nothing
        wr(3'd0, 32'h0);
        base = conv_cnt;
        wr(3'd0, 32'h4000_0000);
        cycles(20);
        chk("R7 no scan when disabled", 32'(conv_cnt - base), 32'h0);
        rd(3'd0, v);
        chk("R7 request not stored", v, 32'h0);

        // R8 edge modes and source selection
        for (int m = 0; m < 4; m++) begin
            for (int si = 0; si < 3; si++) begin
                int s;
                s = (si == 0) ? 0 : (si == 1) ? 5 : 15;
                wr(3'd0, 32'h1 | (32'(s) << 24) | (32'(m) << 28));
                cycles(4);
                base = conv_cnt;
                trig_in[(s + 1) % 16] = 1'b1;
                cycles(20);
                trig_in[(s + 1) % 16] = 1'b0;
                cycles(20);
                chk("R8 unselected line ignored", 32'(conv_cnt - base), 32'h0);
                base = conv_cnt;
                trig_in[s] = 1'b1;
                cycles(20);
                trig_in[s] = 1'b0;
                cycles(20);
                expn = (m == 0) ? 0 : (m == 3) ? 2 : 1;
                chk("R8 scans per edge mode", 32'(conv_cnt - base), 32'(expn));
            end
        end
        wr(3'd0, 32'h0);

        // R9 trigger during scan ignored
        load_list(7);
        wr(3'd0, 32'h1 | (32'd3 << 24) | (32'd1 << 28));
        cycles(4);
        base = conv_cnt;
        trig_in[3] = 1'b1;
        cycles(12);
        trig_in[3] = 1'b0;
        cycles(4);
        trig_in[3] = 1'b1;
        cycles(70);
        trig_in[3] = 1'b0;
        cycles(10);
        chk("R9 single scan despite second edge", 32'(conv_cnt - base), 32'd8);
        wr(3'd0, 32'h0);

        // R10 disable aborts a scan
        load_list(15);
        base = conv_cnt;
        wr(3'd0, 32'h4000_0001);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (conv_cnt - base >= 2) break;
        end
        wr(3'd0, 32'h0);
        cycles(30);
        chk("R10 scan stopped early", 32'(conv_cnt - base <= 3), 32'h1);
        rd(3'd4, v);
        chk("R10 busy low after abort", {31'b0, v[2]}, 32'h0);

        // R11 start queued during scan runs afterwards
        load_list(3);
        base = conv_cnt;
        wr(3'd0, 32'h4000_0001);
        cycles(8);
        wr(3'd0, 32'h4000_0001);
        cycles(80);
        chk("R11 two back-to-back scans", 32'(conv_cnt - base), 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R11 second scan order", {27'b0, chan_log[8'(base + i)]}, {27'b0, pat[i % 4]});
        end
        rd(3'd4, v);
        chk("R11 idle after queued scan", {31'b0, v[2]}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule